// File: doc/BRIEF.md
# Monitor Setup Byte-Stream Register Loader

This block turns a stream of configuration bytes, written by a host over a byte-oriented serial link, into the register set used by a multi-channel window alarm monitor. Each transfer opens with one control byte. That byte carries per-channel alarm-clear requests, a three-bit conversion delay code and an interrupt enable. Threshold records follow it, three bytes each, and each record packs a 12-bit lower and a 12-bit upper limit. A record arrives only for a channel that the current scan limit and input mode make active. In differential mode the odd channels carry no record, and no filler bytes take their place.

The same registers can be read back through a byte-out port, one byte per read request. The readback sequence follows the write format. The only change is that the clear-request field of the control byte always reads as all ones. A start-of-transfer marker sends both the write parser and the readback pointer back to the control byte. Bus framing and acknowledge generation belong to the surrounding link logic.

The write parser has five states. CTRL waits for the control byte. LO_HI collects the lower limit bits 11..4. MID collects the shared nibble byte. HI_LO collects the upper limit bits 7..0 and commits the record. DONE ignores everything until the next marker. Its transitions are CTRL->LO_HI on the control byte, LO_HI->MID, MID->HI_LO, HI_LO->LO_HI when another channel is active, HI_LO->DONE after the last active channel, and any state->CTRL on the marker. The readback serializer has four states: CTRL, LO_HI, MID and HI_LO. It steps through them the same way on each read request and wraps from HI_LO of the last active channel back to CTRL.

Top module: `mon_setup_loader`

## Requirements
- R1: In the control byte, bits 3..1 form the delay code (bit 3 is its MSB) and bit 0 is the interrupt enable. Both are stored when the byte is accepted.
- R2: Control byte bits 7, 6, 5 and 4 request an alarm clear for channels 0, 1, 2 and 3. Each bit set produces a one-cycle pulse on `alarm_clr[k]` in the cycle after acceptance. The bits are not stored.
- R3: A record packs its limits as follows. Byte 1 holds lower[11:4]. Byte 2 holds lower[3:0] in bits 7..4 and upper[11:8] in bits 3..0. Byte 3 holds upper[7:0].
- R4: Records arrive in ascending channel order, and a record for channel k is expected only when k <= `scan_lim`.
- R5: With `diff_mode` high, odd channels get no record. Channel 2 follows channel 0 directly.
- R6: A channel's limits change only when the third byte of its record is accepted. A record cut short by a marker leaves them unchanged.
- R7: Bytes after the last expected record change no register and produce no clear pulse.
- R8: A `sot` pulse restarts both the write parser and the readback pointer at the control byte. `wr_ready` is low during that cycle.
- R9: A read request returns one byte with `rd_valid` in the next cycle. The sequence is the write format with control bits 7..4 forced to 1, and it wraps to the control byte after the last active record.
- R10: After reset, the delay code is 0, the interrupt enable is 0, every lower limit is 0x000, every upper limit is 0xFFF and no clear pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sot | input | 1 | Start-of-transfer marker, one cycle |
| diff_mode | input | 1 | High selects differential (paired) channels |
| scan_lim | input | 2 | Highest channel in the scan |
| wr_valid | input | 1 | Write byte valid |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte can be accepted |
| rd_req | input | 1 | Request next readback byte |
| rd_valid | output | 1 | Readback byte valid |
| rd_data | output | 8 | Readback byte |
| alarm_clr | output | 4 | Per-channel alarm clear pulses |
| delay_code | output | 3 | Conversion delay code |
| int_en | output | 1 | Interrupt enable |
| lo_thr | output | 48 | Lower limits, channel k at bits 12k+11..12k |
| hi_thr | output | 48 | Upper limits, channel k at bits 12k+11..12k |

## Verification
The bench targets the variable record length. It writes a truncated scan followed by trailing bytes of all ones. A parser that did not stop would load an unexpected channel, or would wrap and rewrite the delay code to 7. Differential writes check that channel 2 takes the second record, which fails if odd slots still consume bytes. A record cut off by a marker must leave the old limits in place, which catches byte-by-byte commits. Readback is compared byte for byte against the written stream, including the forced-one nibble and the wrap in both single-ended and differential layouts.

// File: rtl/mon_setup_pkg.sv
package mon_setup_pkg;
    localparam int NCH     = 4;
    localparam int CH_W    = $clog2(NCH);
    localparam int THR_W   = 12;
    localparam int BYTE_W  = 8;
    localparam int DLY_W   = 3;
    localparam int NIB_W   = THR_W - BYTE_W;
    localparam int BANK_W  = NCH * THR_W;

    typedef enum logic [2:0] {
        W_CTRL, W_LO_HI, W_MID, W_HI_LO, W_DONE
    } wr_state_t;

    typedef enum logic [1:0] {
        R_CTRL, R_LO_HI, R_MID, R_HI_LO
    } rd_state_t;

    typedef struct packed {
        logic            ok;
        logic [CH_W-1:0] idx;
    } chan_step_t;

    // Next active channel after cur, given pairing and scan bound.
    function automatic chan_step_t next_chan(input logic [CH_W-1:0] cur,
                                             input logic            diff,
                                             input logic [CH_W-1:0] lim);
        chan_step_t   s;
        logic [CH_W:0] n;
        n     = {1'b0, cur} + (diff ? (CH_W+1)'(2) : (CH_W+1)'(1));
        s.ok  = (n <= {1'b0, lim});
        s.idx = n[CH_W-1:0];
        return s;
    endfunction
endpackage

// File: rtl/msl_write_fsm.sv
module msl_write_fsm
    import mon_setup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sot,
    input  logic              diff_mode,
    input  logic [CH_W-1:0]   scan_lim,
    input  logic              wr_fire,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NCH-1:0]    alarm_clr,
    output logic [DLY_W-1:0]  delay_code,
    output logic              int_en,
    output logic [BANK_W-1:0] lo_thr,
    output logic [BANK_W-1:0] hi_thr
);
    wr_state_t        st, st_n;
    logic [CH_W-1:0]  ch, ch_n;
    logic [BYTE_W-1:0] hold_b1, hold_b2;
    chan_step_t       step;
    logic             take;

    assign take = wr_fire && !sot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= W_CTRL;
            ch <= '0;
        end else begin
            st <= st_n;
            ch <= ch_n;
        end
    end

    always_comb begin
        st_n = st;
        ch_n = ch;
        step = next_chan(ch, diff_mode, scan_lim);
        if (sot) begin
            st_n = W_CTRL;
            ch_n = '0;
        end else if (wr_fire) begin
            unique case (st)
                W_CTRL:  begin st_n = W_LO_HI; ch_n = '0; end
                W_LO_HI: st_n = W_MID;
                W_MID:   st_n = W_HI_LO;
                W_HI_LO: begin
                    if (step.ok) begin
                        st_n = W_LO_HI;
                        ch_n = step.idx;
                    end else begin
                        st_n = W_DONE;
                    end
                end
                W_DONE:  st_n = W_DONE;
                default: st_n = W_CTRL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_clr  <= '0;
            delay_code <= '0;
            int_en     <= 1'b0;
            hold_b1    <= '0;
            hold_b2    <= '0;
            lo_thr     <= '0;
            hi_thr     <= '1;
        end else begin
            alarm_clr <= '0;
            if (take) begin
                unique case (st)
                    W_CTRL: begin
                        for (int k = 0; k < NCH; k++)
                            alarm_clr[k] <= wr_data[BYTE_W-1-k];
                        delay_code <= wr_data[DLY_W:1];
                        int_en     <= wr_data[0];
                    end
                    W_LO_HI: hold_b1 <= wr_data;
                    W_MID:   hold_b2 <= wr_data;
                    W_HI_LO: begin
                        lo_thr[int'(ch)*THR_W +: THR_W] <=
                            {hold_b1, hold_b2[BYTE_W-1 -: NIB_W]};
                        hi_thr[int'(ch)*THR_W +: THR_W] <=
                            {hold_b2[NIB_W-1:0], wr_data};
                    end
                    W_DONE: ;
                    default: ;
                endcase
            end
        end
    end

    // R2: clear requests are single-cycle pulses
    assert_clr_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|alarm_clr) |=> (alarm_clr == '0));

    // R6: limits move only on the closing byte of a record
    assert_thr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && st == W_HI_LO) |=> ($stable(lo_thr) && $stable(hi_thr)));

    // R7: trailing bytes leave control fields untouched
    assert_done_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_DONE && !sot) |=>
            ($stable(delay_code) && $stable(int_en) && alarm_clr == '0));
endmodule

// File: rtl/msl_read_ser.sv
module msl_read_ser
    import mon_setup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sot,
    input  logic              diff_mode,
    input  logic [CH_W-1:0]   scan_lim,
    input  logic              rd_req,
    input  logic [DLY_W-1:0]  delay_code,
    input  logic              int_en,
    input  logic [BANK_W-1:0] lo_thr,
    input  logic [BANK_W-1:0] hi_thr,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);
    rd_state_t        rs, rs_n;
    logic [CH_W-1:0]  ch, ch_n;
    logic [THR_W-1:0] lo_k, hi_k;
    logic [BYTE_W-1:0] cur_byte;
    chan_step_t       step;
    logic             take;

    assign take = rd_req && !sot;
    assign lo_k = lo_thr[int'(ch)*THR_W +: THR_W];
    assign hi_k = hi_thr[int'(ch)*THR_W +: THR_W];

    always_comb begin
        unique case (rs)
            R_CTRL:  cur_byte = {{NCH{1'b1}}, delay_code, int_en};
            R_LO_HI: cur_byte = lo_k[THR_W-1 -: BYTE_W];
            R_MID:   cur_byte = {lo_k[NIB_W-1:0], hi_k[THR_W-1 -: NIB_W]};
            R_HI_LO: cur_byte = hi_k[BYTE_W-1:0];
            default: cur_byte = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs <= R_CTRL;
            ch <= '0;
        end else begin
            rs <= rs_n;
            ch <= ch_n;
        end
    end

    always_comb begin
        rs_n = rs;
        ch_n = ch;
        step = next_chan(ch, diff_mode, scan_lim);
        if (sot) begin
            rs_n = R_CTRL;
            ch_n = '0;
        end else if (rd_req) begin
            unique case (rs)
                R_CTRL:  begin rs_n = R_LO_HI; ch_n = '0; end
                R_LO_HI: rs_n = R_MID;
                R_MID:   rs_n = R_HI_LO;
                R_HI_LO: begin
                    rs_n = step.ok ? R_LO_HI : R_CTRL;
                    ch_n = step.ok ? step.idx : '0;
                end
                default: rs_n = R_CTRL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take;
            if (take) rd_data <= cur_byte;
        end
    end

    // R9: each request yields a byte next cycle
    assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rd_valid);

    // R9: control byte reads with clear field forced high
    assert_rb_ctrl_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rs == R_CTRL) |=> (rd_data[BYTE_W-1 -: NCH] == {NCH{1'b1}}));
endmodule

// File: rtl/mon_setup_loader.sv
module mon_setup_loader
    import mon_setup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sot,
    input  logic              diff_mode,
    input  logic [CH_W-1:0]   scan_lim,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic [NCH-1:0]    alarm_clr,
    output logic [DLY_W-1:0]  delay_code,
    output logic              int_en,
    output logic [BANK_W-1:0] lo_thr,
    output logic [BANK_W-1:0] hi_thr
);
    logic wr_fire;

    assign wr_ready = !sot;
    assign wr_fire  = wr_valid && wr_ready;

    msl_write_fsm u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sot        (sot),
        .diff_mode  (diff_mode),
        .scan_lim   (scan_lim),
        .wr_fire    (wr_fire),
        .wr_data    (wr_data),
        .alarm_clr  (alarm_clr),
        .delay_code (delay_code),
        .int_en     (int_en),
        .lo_thr     (lo_thr),
        .hi_thr     (hi_thr)
    );

    msl_read_ser u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sot        (sot),
        .diff_mode  (diff_mode),
        .scan_lim   (scan_lim),
        .rd_req     (rd_req),
        .delay_code (delay_code),
        .int_en     (int_en),
        .lo_thr     (lo_thr),
        .hi_thr     (hi_thr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );
endmodule

// File: tb/mon_setup_loader_tb.sv
module mon_setup_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sot = 1'b0;
    logic        diff_mode = 1'b0;
    logic [1:0]  scan_lim = 2'd3;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_ready;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [3:0]  alarm_clr;
    logic [2:0]  delay_code;
    logic        int_en;
    logic [47:0] lo_thr, hi_thr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [11:0] exp_lo [4];
    logic [11:0] exp_hi [4];
    logic [7:0]  stream [16];
    int          slen;

    always #5 clk = ~clk;

    mon_setup_loader u_dut (
        .clk(clk), .rst_n(rst_n), .sot(sot), .diff_mode(diff_mode),
        .scan_lim(scan_lim), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .alarm_clr(alarm_clr), .delay_code(delay_code),
        .int_en(int_en), .lo_thr(lo_thr), .hi_thr(hi_thr)
    );

    task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        for (int k = 0; k < 4; k++) begin
            check({tag, " lo"}, 48'(lo_thr[k*12 +: 12]), 48'(exp_lo[k]));
            check({tag, " hi"}, 48'(hi_thr[k*12 +: 12]), 48'(exp_hi[k]));
        end
    endtask

    task automatic pulse_sot();
        @(negedge clk); sot = 1'b1;
        #1 check("R8 wr_ready low on sot", 48'(wr_ready), 48'(0));
        @(negedge clk); sot = 1'b0;
        slen = 0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_data = b;
        @(negedge clk); wr_valid = 1'b0;
        if (slen < 16) begin stream[slen] = b; slen++; end
    endtask

    task automatic send_ctrl(input logic [7:0] b, input logic [3:0] exp_clr);
        send(b);
        check("R2 clear pulse", 48'(alarm_clr), 48'(exp_clr));
        check("R1 delay", 48'(delay_code), 48'(b[3:1]));
        check("R1 int_en", 48'(int_en), 48'(b[0]));
        @(negedge clk);
        check("R2 clear one cycle", 48'(alarm_clr), 48'(0));
    endtask

    task automatic send_rec(input int k, input logic [11:0] lo, input logic [11:0] hi, input bit expect_load);
        send(lo[11:4]);
        send({lo[3:0], hi[11:8]});
        send(hi[7:0]);
        if (expect_load) begin exp_lo[k] = lo; exp_hi[k] = hi; end
    endtask

    task automatic read_byte(output logic [7:0] b);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        check("R9 rd_valid", 48'(rd_valid), 48'(1));
        b = rd_data;
    endtask

    task automatic t_reset();
        check("R10 delay reset", 48'(delay_code), 48'(0));
        check("R10 int_en reset", 48'(int_en), 48'(0));
        check("R10 clr reset", 48'(alarm_clr), 48'(0));
        check("R10 rd_valid reset", 48'(rd_valid), 48'(0));
        check_bank("R10 bank reset");
    endtask

    task automatic t_full_single();
        diff_mode = 1'b0; scan_lim = 2'd3;
        pulse_sot();
        send_ctrl(8'hA7, 4'b0101);
        send_rec(0, 12'h123, 12'hABC, 1);
        send_rec(1, 12'h456, 12'hDEF, 1);
        send_rec(2, 12'h001, 12'h800, 1);
        send_rec(3, 12'h7FF, 12'h0FE, 1);
        check_bank("R3 R4 full scan");
    endtask

    task automatic t_short_scan();
        diff_mode = 1'b0; scan_lim = 2'd1;
        pulse_sot();
        send_ctrl(8'h00, 4'b0000);
        send_rec(0, 12'h111, 12'h222, 1);
        send_rec(1, 12'h333, 12'h444, 1);
        for (int i = 0; i < 3; i++) begin
            send(8'hFF);
            check("R7 no clear on trailing", 48'(alarm_clr), 48'(0));
        end
        check("R7 delay kept", 48'(delay_code), 48'(0));
        check("R7 int_en kept", 48'(int_en), 48'(0));
        check_bank("R4 R7 short scan");
    endtask

    task automatic t_diff();
        diff_mode = 1'b1; scan_lim = 2'd3;
        pulse_sot();
        send_ctrl(8'h12, 4'b1000);
        send_rec(0, 12'hAAA, 12'hBBB, 1);
        send_rec(2, 12'hCCC, 12'hDDD, 1);
        send(8'hFF);
        check("R7 diff trailing delay", 48'(delay_code), 48'(1));
        check_bank("R5 diff pairs");
    endtask

    task automatic t_partial();
        diff_mode = 1'b0; scan_lim = 2'd3;
        pulse_sot();
        send_ctrl(8'h02, 4'b0000);
        send(8'h99);
        send(8'h99);
        pulse_sot();
        check_bank("R6 partial record");
        send_ctrl(8'h04, 4'b0000);
        send_rec(0, 12'h5A5, 12'hA5A, 1);
        check_bank("R8 restart parse");
    endtask

    task automatic t_readback(input logic d, input logic [1:0] lim, input logic [7:0] ctl);
        logic [7:0] b;
        int n;
        diff_mode = d; scan_lim = lim;
        pulse_sot();
        send_ctrl(ctl, ctl[7:4] == 4'hF ? 4'hF : {ctl[4], ctl[5], ctl[6], ctl[7]});
        send_rec(0, 12'h3C5, 12'hE21, 1);
        if (!d && lim >= 1) send_rec(1, 12'h0F0, 12'h9A9, 1);
        if (lim >= 2) send_rec(2, 12'h444, 12'hBCD, 1);
        if (!d && lim >= 3) send_rec(3, 12'h765, 12'hFED, 1);
        n = slen;
        stream[0] = {4'hF, stream[0][3:0]};
        pulse_sot();
        for (int i = 0; i < n; i++) begin
            read_byte(b);
            check("R9 readback byte", 48'(b), 48'(stream[i]));
        end
        read_byte(b);
        check("R9 readback wrap", 48'(b), 48'({4'hF, ctl[3:0]}));
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin exp_lo[k] = 12'h000; exp_hi[k] = 12'hFFF; end
        slen = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_single();
        t_short_scan();
        t_diff();
        t_partial();
        t_readback(1'b0, 2'd3, 8'h35);
        t_readback(1'b1, 2'd2, 8'hF9);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule